// File: doc/BRIEF.md
# Mixed-Width Instruction Fetch Unit

This block fetches one instruction for a processor core that runs three instruction streams: a fixed 32-bit stream in the wide execution state, a fixed 32-bit stream in the narrow execution state, and a compact stream in the narrow state that mixes 16-bit and 32-bit instructions. A fetch begins on a start pulse. The block captures the program counter, the execution-width flag, the compact-mode flag and the 8-bit if-then state. It then issues one or two reads on a synchronous memory port with a valid/ready handshake.

The block returns a 32-bit instruction word, a 2-bit encoding-class tag and a default 4-bit condition. In compact mode the block reads the first halfword and uses its top five bits to find the instruction length. It makes a second halfword read only when the instruction is a 32-bit form.

The PC alignment check runs before any memory traffic. A misaligned PC ends the fetch at once with a fault pulse and no read. Execution, full decode, exception entry and address translation belong to other blocks.

Top module: `ifu_fetch`

## Requirements
- R1: With the width flag set (wide state), a PC whose bits [1:0] are not 00 faults. Otherwise the block makes one word read (mem_half_o=0) at the full 64-bit PC, returns the word unchanged and tags it 2'b00.
- R2: With the width flag clear and the compact flag clear, the block makes one word read at address {32'b0, PC[31:0]}, returns the word unchanged and tags it 2'b01.
- R3: In compact mode the block reads a halfword (mem_half_o=1, data in mem_rdata_i[15:0]) at {32'b0, PC[31:0]}. If bits [15:11] of that halfword are below 5'b11101, it makes no further read, returns {16'h0000, halfword} and tags it 2'b10.
- R4: In compact mode, if bits [15:11] of the first halfword are 5'b11101 or above, the block reads a second halfword at {32'b0, (PC[31:0]+2) mod 2^32}. It returns {first, second}, with the first halfword in bits [31:16], and tags it 2'b11.
- R5: With the width flag clear, a fetch faults when PC[0] is 1. It also faults when the compact flag is clear and PC[1] is 1.
- R6: The default condition is 4'hE for tags 2'b00 and 2'b01, and also whenever IT[3:0] is 4'h0. Otherwise it is IT[7:4].
- R7: A faulting fetch issues no memory request. It raises fault_o for exactly one cycle, in the same cycle as done_o.
- R8: While a request waits for mem_ready_i, the block holds mem_valid_o high and mem_addr_o stable. done_o lasts one cycle, and instr_o, enc_o and cond_o hold their values until a later fetch completes.
- R9: After reset, done_o, fault_o and mem_valid_o are low, and instr_o, enc_o and cond_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a fetch when the block is idle |
| pc_i | input | 64 | Program counter |
| wide_i | input | 1 | 1 = wide (64-bit) execution state |
| compact_i | input | 1 | 1 = compact mixed-length stream (narrow state only) |
| it_i | input | 8 | If-then state |
| mem_valid_o | output | 1 | Read request valid |
| mem_addr_o | output | 64 | Read address |
| mem_half_o | output | 1 | 1 = halfword read, 0 = word read |
| mem_ready_i | input | 1 | Memory accepts the request and returns data in this cycle |
| mem_rdata_i | input | 32 | Read data; a halfword read uses bits [15:0] |
| instr_o | output | 32 | Fetched instruction |
| enc_o | output | 2 | Encoding class: 00 wide, 01 narrow fixed, 10 compact 16, 11 compact 32 |
| cond_o | output | 4 | Default condition |
| fault_o | output | 1 | PC alignment fault pulse |
| done_o | output | 1 | Fetch complete pulse |

## Verification
On every cycle, the assertions check the following:
- The request is held stable until it is accepted.
- done_o and fault_o are single-cycle pulses, and they occur together on a fault.
- A fault never coincides with a request.
- Word reads are always word-aligned.
- The fixed-width tags always carry the always-condition.
- The outputs stay unchanged while the block is idle.

Only the bench scenarios can show the rest:
- The length split at the 5'b11100/5'b11101 boundary.
- The halfword packing order.
- The second address wrapping past 2^32.
- The alignment faults in each mode.
- The condition taken from the if-then state.
- The exact number of reads each kind of fetch makes.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef enum logic [1:0] {
    ENC_W64 = 2'b00,
    ENC_W32 = 2'b01,
    ENC_C16 = 2'b10,
    ENC_C32 = 2'b11
  } enc_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_FIRST  = 2'b01,
    ST_SECOND = 2'b10
  } fetch_st_e;

  localparam int unsigned HALF_W  = 16;
  localparam int unsigned WORD_W  = 32;
  localparam logic [3:0]  COND_AL = 4'hE;
endpackage

// File: rtl/ifu_align_chk.sv
module ifu_align_chk (
  input  logic [1:0] pc_lo_i,
  input  logic       wide_i,
  input  logic       compact_i,
  output logic       fault_o
);
  always_comb begin
    if (wide_i) fault_o = |pc_lo_i;
    else        fault_o = pc_lo_i[0] | (~compact_i & pc_lo_i[1]);
  end
endmodule

// File: rtl/ifu_len_dec.sv
module ifu_len_dec #(
  parameter int unsigned HW_W    = 16,
  parameter int unsigned OP_BITS = 5,
  parameter logic [4:0]  LONG_MIN = 5'b11101
) (
  input  logic [HW_W-1:0] hw_i,
  output logic            long_o
);
  localparam int unsigned OP_LSB = HW_W - OP_BITS;
  logic [OP_BITS-1:0] op;
  assign op     = hw_i[HW_W-1:OP_LSB];
  assign long_o = (op >= LONG_MIN[OP_BITS-1:0]);
endmodule

// File: rtl/ifu_cond_gen.sv
module ifu_cond_gen
  import ifu_pkg::*;
#(
  parameter int unsigned IT_W = 8
) (
  input  enc_e            enc_i,
  input  logic [IT_W-1:0] it_i,
  output logic [3:0]      cond_o
);
  localparam int unsigned HALF_IT = IT_W / 2;
  logic fixed_cls;
  assign fixed_cls = (enc_i == ENC_W64) || (enc_i == ENC_W32);

  always_comb begin
    if (fixed_cls || (it_i[HALF_IT-1:0] == '0)) cond_o = COND_AL;
    else                                        cond_o = it_i[IT_W-1:IT_W-4];
  end
endmodule

// File: rtl/ifu_fetch.sv
module ifu_fetch
  import ifu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned IT_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              wide_i,
  input  logic              compact_i,
  input  logic [IT_W-1:0]   it_i,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_half_o,
  input  logic              mem_ready_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] instr_o,
  output logic [1:0]        enc_o,
  output logic [3:0]        cond_o,
  output logic              fault_o,
  output logic              done_o
);
  localparam int unsigned PAD_W = ADDR_W - NARROW_W;
  localparam logic [NARROW_W-1:0] HALF_STEP = NARROW_W'(2);

  fetch_st_e         state_q;
  logic [ADDR_W-1:0] pc_q;
  logic              wide_q, compact_q;
  logic [IT_W-1:0]   it_q;
  logic [HALF_W-1:0] hw1_q;
  logic [WORD_W-1:0] instr_q;
  enc_e              enc_q;
  logic [3:0]        cond_q;
  logic              done_q, fault_q;

  logic              fault_w, long_w;
  enc_e              next_enc;
  logic [3:0]        cond_w;
  logic [NARROW_W-1:0] narrow_addr;

  ifu_align_chk u_align (
    .pc_lo_i  (pc_i[1:0]),
    .wide_i   (wide_i),
    .compact_i(compact_i),
    .fault_o  (fault_w)
  );

  ifu_len_dec #(.HW_W(HALF_W)) u_len (
    .hw_i  (mem_rdata_i[HALF_W-1:0]),
    .long_o(long_w)
  );

  always_comb begin
    if (state_q == ST_SECOND) next_enc = ENC_C32;
    else if (wide_q)          next_enc = ENC_W64;
    else if (!compact_q)      next_enc = ENC_W32;
    else if (long_w)          next_enc = ENC_C32;
    else                      next_enc = ENC_C16;
  end

  ifu_cond_gen #(.IT_W(IT_W)) u_cond (
    .enc_i (next_enc),
    .it_i  (it_q),
    .cond_o(cond_w)
  );

  // narrow-state addresses wrap inside the low 32 bits
  assign narrow_addr = pc_q[NARROW_W-1:0] + ((state_q == ST_SECOND) ? HALF_STEP : '0);

  generate
    if (PAD_W > 0) begin : g_pad
      assign mem_addr_o = wide_q ? pc_q : {{PAD_W{1'b0}}, narrow_addr};
    end else begin : g_nopad
      assign mem_addr_o = wide_q ? pc_q : narrow_addr;
    end
  endgenerate

  assign mem_valid_o = (state_q == ST_FIRST) || (state_q == ST_SECOND);
  assign mem_half_o  = compact_q & ~wide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pc_q      <= '0;
      wide_q    <= 1'b0;
      compact_q <= 1'b0;
      it_q      <= '0;
      hw1_q     <= '0;
      instr_q   <= '0;
      enc_q     <= ENC_W64;
      cond_q    <= '0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            pc_q      <= pc_i;
            wide_q    <= wide_i;
            compact_q <= compact_i & ~wide_i;
            it_q      <= it_i;
            if (fault_w) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
            end else begin
              state_q <= ST_FIRST;
            end
          end
        end
        ST_FIRST: begin
          if (mem_ready_i) begin
            if (next_enc == ENC_C32) begin
              hw1_q   <= mem_rdata_i[HALF_W-1:0];
              state_q <= ST_SECOND;
            end else begin
              instr_q <= (next_enc == ENC_C16) ? {{(WORD_W-HALF_W){1'b0}}, mem_rdata_i[HALF_W-1:0]}
                                                : mem_rdata_i;
              enc_q   <= next_enc;
              cond_q  <= cond_w;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_SECOND: begin
          if (mem_ready_i) begin
            instr_q <= {hw1_q, mem_rdata_i[HALF_W-1:0]};
            enc_q   <= next_enc;
            cond_q  <= cond_w;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign instr_o = instr_q;
  assign enc_o   = enc_q;
  assign cond_o  = cond_q;
  assign done_o  = done_q;
  assign fault_o = fault_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)) else $error("req hold"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done pulse"); // R8
  AST_FAULT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o) else $error("fault without done"); // R7
  AST_FAULT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !mem_valid_o) else $error("fault with request"); // R7
  AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_half_o |-> mem_addr_o[1:0] == 2'b00) else $error("word misaligned"); // R5
  AST_FIXED_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o && !enc_o[1] |-> cond_o == COND_AL) else $error("fixed cond"); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && !start_i |=> $stable(instr_o) && $stable(enc_o) && $stable(cond_o)) else $error("out hold"); // R8
endmodule

// File: tb/tb_ifu_fetch.sv
module tb_ifu_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic        wide;
    logic        compact;
    logic [7:0]  it;
    logic [63:0] pc;
    logic [31:0] d1;
    logic [15:0] d2;
    logic        fault;
    logic [31:0] instr;
    logic [1:0]  enc;
    logic [3:0]  cond;
    logic [1:0]  nrd;
    logic [63:0] a1;
    logic [63:0] a2;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    // R1 wide aligned
    '{1'b1,1'b0,8'h5A,64'h0000_0001_0000_1000,32'h9100_0421,16'h0,1'b0,32'h9100_0421,2'b00,4'hE,2'd1,64'h0000_0001_0000_1000,64'h0},
    // R1 wide misaligned bit1
    '{1'b1,1'b0,8'h00,64'h0000_0001_0000_1002,32'h0,16'h0,1'b1,32'h0,2'b00,4'h0,2'd0,64'h0,64'h0},
    // R1 wide misaligned bit0
    '{1'b1,1'b1,8'h00,64'h0000_0001_0000_1001,32'h0,16'h0,1'b1,32'h0,2'b00,4'h0,2'd0,64'h0,64'h0},
    // R2 narrow fixed, high PC bits dropped
    '{1'b0,1'b0,8'h00,64'hFFFF_FFFF_8000_0004,32'hE3A0_0001,16'h0,1'b0,32'hE3A0_0001,2'b01,4'hE,2'd1,64'h0000_0000_8000_0004,64'h0},
    // R5 narrow fixed, PC[1] set
    '{1'b0,1'b0,8'h00,64'h0000_0000_8000_0006,32'h0,16'h0,1'b1,32'h0,2'b00,4'h0,2'd0,64'h0,64'h0},
    // R5 narrow fixed, PC[0] set
    '{1'b0,1'b0,8'h00,64'h0000_0000_8000_0001,32'h0,16'h0,1'b1,32'h0,2'b00,4'h0,2'd0,64'h0,64'h0},
    // R3 compact short, PC[1] allowed
    '{1'b0,1'b1,8'h00,64'h0000_0000_0000_2002,32'h0000_4770,16'h0,1'b0,32'h0000_4770,2'b10,4'hE,2'd1,64'h0000_0000_0000_2002,64'h0},
    // R3 boundary 11100 short, R6 cond from IT
    '{1'b0,1'b1,8'h38,64'h0000_0000_0000_2004,32'h0000_E7FE,16'h0,1'b0,32'h0000_E7FE,2'b10,4'h3,2'd1,64'h0000_0000_0000_2004,64'h0},
    // R4 boundary 11101 long, R6 cond 0
    '{1'b0,1'b1,8'h04,64'h0000_0000_0000_3000,32'h0000_E800,16'h1234,1'b0,32'hE800_1234,2'b11,4'h0,2'd2,64'h0000_0000_0000_3000,64'h0000_0000_0000_3002},
    // R4 wrap of second address, R6 IT low zero
    '{1'b0,1'b1,8'hA0,64'h0000_0007_FFFF_FFFE,32'h0000_F000,16'hBC00,1'b0,32'hF000_BC00,2'b11,4'hE,2'd2,64'h0000_0000_FFFF_FFFE,64'h0},
    // R5 compact odd PC
    '{1'b0,1'b1,8'h00,64'h0000_0000_0000_2003,32'h0,16'h0,1'b1,32'h0,2'b00,4'h0,2'd0,64'h0,64'h0},
    // R6 narrow fixed ignores IT
    '{1'b0,1'b0,8'hF1,64'h0000_0000_0000_4000,32'h1234_5678,16'h0,1'b0,32'h1234_5678,2'b01,4'hE,2'd1,64'h0000_0000_0000_4000,64'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] pc = '0;
  logic        wide = 1'b0, compact = 1'b0;
  logic [7:0]  it = '0;
  logic        mem_valid, mem_half, mem_ready = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [31:0] instr;
  logic [1:0]  enc;
  logic [3:0]  cond;
  logic        fault, done;

  int checks = 0, fails = 0;
  int lat = 0, wcnt = 0, rd_cnt = 0;
  logic [31:0] cur_d1;
  logic [15:0] cur_d2;
  logic [63:0] got_a1, got_a2;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifu_fetch dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pc_i(pc), .wide_i(wide),
    .compact_i(compact), .it_i(it), .mem_valid_o(mem_valid), .mem_addr_o(mem_addr),
    .mem_half_o(mem_half), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .instr_o(instr), .enc_o(enc), .cond_o(cond), .fault_o(fault), .done_o(done)
  );

  // memory model: responds after lat idle cycles, garbage in upper half for halfword reads
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_valid) begin
      if (wcnt >= lat) begin
        mem_ready = 1'b1;
        if (rd_cnt == 0) begin
          got_a1 = mem_addr;
          mem_rdata = mem_half ? {16'hDEAD, cur_d1[15:0]} : cur_d1;
        end else begin
          got_a2 = mem_addr;
          mem_rdata = {16'hBEEF, cur_d2};
        end
        rd_cnt++;
      end else wcnt++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_fetch(input vec_t v, input int l, output bit ok);
    int n = 0;
    @(negedge clk);
    rd_cnt = 0; wcnt = 0; lat = l;
    cur_d1 = v.d1; cur_d2 = v.d2;
    got_a1 = '0; got_a2 = '0;
    pc = v.pc; wide = v.wide; compact = v.compact; it = v.it;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    ok = done;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    logic [31:0] held_instr;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 done", done, 0);
    chk("R9 fault", fault, 0);
    chk("R9 valid", mem_valid, 0);
    chk("R9 instr", instr, 0);
    chk("R9 enc", enc, 0);
    chk("R9 cond", cond, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_fetch(VECS[i], i % 3, ok);
      chk($sformatf("R8 done v%0d", i), ok, 1);
      chk($sformatf("R7 fault v%0d", i), fault, VECS[i].fault);
      chk($sformatf("R7 reads v%0d", i), rd_cnt, VECS[i].nrd);
      if (!VECS[i].fault) begin
        chk($sformatf("R3/R4 instr v%0d", i), instr, VECS[i].instr);
        chk($sformatf("R1/R2 enc v%0d", i), enc, VECS[i].enc);
        chk($sformatf("R6 cond v%0d", i), cond, VECS[i].cond);
        chk($sformatf("R2 addr1 v%0d", i), got_a1, VECS[i].a1);
        if (VECS[i].nrd == 2) chk($sformatf("R4 addr2 v%0d", i), got_a2, VECS[i].a2);
      end
      held_instr = instr;
      @(negedge clk);
      chk($sformatf("R8 done low v%0d", i), done, 0);
      chk($sformatf("R7 fault low v%0d", i), fault, 0);
      chk($sformatf("R8 instr held v%0d", i), instr, held_instr);
    end

    // R8: outputs held for many idle cycles while inputs move
    run_fetch(VECS[8], 0, ok);
    held_instr = instr;
    pc = 64'h3; wide = 1'b1; it = 8'hFF;
    repeat (5) @(negedge clk);
    chk("R8 long hold instr", instr, held_instr);
    chk("R8 long hold enc", enc, 2'b11);
    chk("R8 long hold cond", cond, 4'h0);
    chk("R8 no request", mem_valid, 0);

    // R7: fault after a good fetch keeps the previous result and makes no read
    run_fetch(VECS[4], 0, ok);
    chk("R7 fault after good", fault, 1);
    chk("R7 no read", rd_cnt, 0);
    chk("R7 instr kept", instr, held_instr);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule